// File: doc/BRIEF.md
# Segmented Address and Byte-Lane Sequencer

This unit turns a segment-relative memory request into one or two bus cycles on a 16-bit data path. The data path is split into an even bank on the low byte lane and an odd bank on the high byte lane. The unit holds four 16-bit segment bases. For each request it forms a 20-bit physical address by shifting the selected base left by four bits and adding the 16-bit offset. It then drives the address, an active-low upper-lane enable and two segment status bits until the memory side signals ready.

A byte access, or a word access at an even address, takes a single bus cycle. A word access at an odd address is split into two cycles. The first cycle moves the low byte through the odd bank at the odd address. The second cycle moves the high byte through the even bank at the next address. For reads, the unit realigns the lanes into a right-justified result. A one-cycle done pulse marks the end of each transfer. The segment bases are written through a simple load port.

Top module: `seg_lane_unit`

## Requirements
- R1: The bus address is ((base << 4) + offset) truncated to 20 bits, so a sum above FFFFFh wraps to the bottom of memory.
- R2: After reset, the code base (select 2'b10) is FFFFh and the other three bases are 0. A request on the code base with offset 0 addresses FFFF0h. While idle after reset, bus_cyc=0, done=0 and upper_en_n=1.
- R3: When seg_wr is high, seg_wdata is written to the base chosen by seg_sel (00 extra, 01 stack, 10 code, 11 data), and the other bases are left unchanged.
- R4: During every bus cycle, seg_stat equals the select of the request: 00 extra, 01 stack, 10 code, 11 data.
- R5: A byte access at an even address takes one cycle with upper_en_n=1 and addr[0]=0. Write data appears on lanes 7..0. Read data is taken from lanes 7..0 into rdata[7:0], with rdata[15:8]=0.
- R6: A byte access at an odd address takes one cycle with upper_en_n=0 and addr[0]=1. The write byte appears on lanes 15..8. The read byte is taken from lanes 15..8 into rdata[7:0], with rdata[15:8]=0.
- R7: A word access at an even address takes one cycle with upper_en_n=0, moving bits 7..0 on lanes 7..0 and bits 15..8 on lanes 15..8.
- R8: A word access at an odd address takes two cycles. The first is at the odd address with upper_en_n=0 and moves bits 7..0 on lanes 15..8. The second is at address+1 (wrapping at 20 bits) with upper_en_n=1 and moves bits 15..8 on lanes 7..0.
- R9: A bus cycle stays active while ready is low, with addr, upper_en_n and seg_stat held steady.
- R10: done is high for exactly one clock, in the cycle after the final bus cycle is accepted with ready. rdata is valid from that cycle onward.
- R11: A request raised while a transfer is in progress is ignored. It changes neither the current cycle nor the cycles that follow the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| seg_wr | input | 1 | Load the selected segment base |
| seg_wdata | input | 16 | New segment base value |
| req | input | 1 | Start a transfer (sampled while idle) |
| seg_sel | input | 2 | Segment select for the load or the request |
| offset | input | 16 | Effective address within the segment |
| word | input | 1 | 1 for a word access, 0 for a byte access |
| wr | input | 1 | 1 for write, 0 for read |
| wdata | input | 16 | Write data, right-justified |
| ready | input | 1 | Memory side completes the current bus cycle |
| bus_rdata | input | 16 | Read data lanes from memory |
| bus_cyc | output | 1 | A bus cycle is active |
| bus_wr | output | 1 | The active cycle is a write |
| addr | output | 20 | Physical byte address |
| upper_en_n | output | 1 | Active-low enable of the high byte lane |
| seg_stat | output | 2 | Segment in use |
| bus_wdata | output | 16 | Write data lanes |
| rdata | output | 16 | Realigned read result |
| done | output | 1 | One-cycle transfer-complete pulse |

## Verification
The embedded properties check on every cycle that a cycle held by a low ready keeps its address and lane enable steady. They also check that any odd address drives the upper lane, that a follow-on cycle sits one byte above the previous one with the upper lane off, and that done is a single-cycle pulse that only follows an accepted cycle. Only the bench scenarios can show the arithmetic of the address sum and its wrap, the reset values of the four bases, the per-lane placement of write data and the reassembly of split reads. The same holds for ignoring a request raised mid-transfer, because these depend on values the bench predicts from the request.

// File: rtl/seg_lane_unit.sv
module seg_lane_unit #(
  parameter int          SEG_W    = 16,
  parameter logic [15:0] CODE_RST = 16'hFFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         seg_wr,
  input  logic [15:0]  seg_wdata,
  input  logic         req,
  input  logic [1:0]   seg_sel,
  input  logic [15:0]  offset,
  input  logic         word,
  input  logic         wr,
  input  logic [15:0]  wdata,
  input  logic         ready,
  input  logic [15:0]  bus_rdata,
  output logic         bus_cyc,
  output logic         bus_wr,
  output logic [19:0]  addr,
  output logic         upper_en_n,
  output logic [1:0]   seg_stat,
  output logic [15:0]  bus_wdata,
  output logic [15:0]  rdata,
  output logic         done
);

  localparam int PA_W   = SEG_W + 4;
  localparam int N_SEG  = 4;
  localparam logic [1:0] CODE_IDX = 2'b10;

  typedef enum logic [1:0] {ST_IDLE, ST_FIRST, ST_SECOND} st_t;

  st_t              st;
  logic [SEG_W-1:0] base_q [N_SEG];
  logic [PA_W-1:0]  pa_q;
  logic             word_q, wr_q;
  logic [15:0]      wd_q;
  logic [1:0]       sel_q;
  logic             split;
  logic             last;
  logic [PA_W-1:0]  pa_calc;

  assign pa_calc = {base_q[seg_sel], 4'b0000} + {4'b0000, offset};
  assign split   = word_q & pa_q[0];
  assign last    = ready & ((st == ST_FIRST & ~split) | st == ST_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_SEG; i++)
        base_q[i] <= (2'(i) == CODE_IDX) ? CODE_RST : '0;
    end else if (seg_wr) begin
      base_q[seg_sel] <= seg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      pa_q   <= {CODE_RST, 4'b0000};
      word_q <= 1'b0;
      wr_q   <= 1'b0;
      wd_q   <= '0;
      sel_q  <= CODE_IDX;
      rdata  <= '0;
      done   <= 1'b0;
    end else begin
      done <= last;
      case (st)
        ST_IDLE: if (req) begin
          st     <= ST_FIRST;
          pa_q   <= pa_calc;
          word_q <= word;
          wr_q   <= wr;
          wd_q   <= wdata;
          sel_q  <= seg_sel;
        end
        ST_FIRST: if (ready) begin
          st <= split ? ST_SECOND : ST_IDLE;
          if (!wr_q) begin
            if (split)       rdata[7:0] <= bus_rdata[15:8];
            else if (word_q) rdata      <= bus_rdata;
            else if (pa_q[0]) rdata     <= {8'h00, bus_rdata[15:8]};
            else             rdata      <= {8'h00, bus_rdata[7:0]};
          end
        end
        ST_SECOND: if (ready) begin
          st <= ST_IDLE;
          if (!wr_q) rdata[15:8] <= bus_rdata[7:0];
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign bus_cyc    = (st != ST_IDLE);
  assign bus_wr     = bus_cyc & wr_q;
  assign addr       = (st == ST_SECOND) ? pa_q + PA_W'(1) : pa_q;
  assign upper_en_n = (st == ST_FIRST) ? ~(word_q | pa_q[0]) : 1'b1;
  assign seg_stat   = sel_q;
  assign bus_wdata  = (st == ST_SECOND)               ? {2{wd_q[15:8]}} :
                      (word_q & ~pa_q[0])             ? wd_q            :
                                                        {2{wd_q[7:0]}};

  AST_HOLD_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && !ready |=> bus_cyc && $stable(addr) && $stable(upper_en_n) && $stable(seg_stat)); // R9
  AST_ODD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && addr[0] |-> !upper_en_n); // R6
  AST_NEXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cyc && $past(bus_cyc && ready) |-> addr == PA_W'($past(addr) + PA_W'(1)) && upper_en_n); // R8
  AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(bus_cyc && ready) && !bus_cyc); // R10

endmodule

// File: tb/test_seg_lane_unit.sv
`timescale 1ns/1ps
module test_seg_lane_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic seg_wr = 0, req = 0, word = 0, wr = 0, ready = 0;
  logic [15:0] seg_wdata = 0, offset = 0, wdata = 0, bus_rdata, bus_wdata, rdata;
  logic [1:0] seg_sel = 0, seg_stat;
  logic bus_cyc, bus_wr, upper_en_n, done;
  logic [19:0] addr;
  int n_chk = 0, n_bad = 0;
  logic [15:0] segm [4];

  always #2 clk = ~clk;

  seg_lane_unit i_seg_lane_unit (.clk, .rst_n, .seg_wr, .seg_wdata, .req, .seg_sel,
    .offset, .word, .wr, .wdata, .ready, .bus_rdata, .bus_cyc, .bus_wr, .addr,
    .upper_en_n, .seg_stat, .bus_wdata, .rdata, .done);

  function automatic logic [7:0] mb(input logic [19:0] a);
    return a[7:0] ^ {a[15:12], a[19:16]} ^ 8'h5A;
  endfunction
  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    return 20'({s, 4'b0000} + {4'b0000, o});
  endfunction

  assign bus_rdata = {mb({addr[19:1], 1'b1}), mb({addr[19:1], 1'b0})};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic seg_load(input logic [1:0] s, input logic [15:0] v);
    @(negedge clk);
    seg_wr = 1; seg_sel = s; seg_wdata = v;
    @(posedge clk); #1 seg_wr = 0;
    segm[s] = v;
  endtask

  task automatic xfer(input logic [1:0] s, input logic [15:0] o, input logic wd,
                      input logic w, input logic [15:0] dat, input int maxw,
                      input bit poke, input string atag);
    logic [19:0] pa;
    int ncyc;
    string tag;
    logic [15:0] exprd;
    pa = phys(segm[s], o);
    ncyc = (wd && pa[0]) ? 2 : 1;
    tag = !wd ? (pa[0] ? "R6" : "R5") : (pa[0] ? "R8" : "R7");
    exprd = wd ? {mb(20'(pa + 20'd1)), mb(pa)} : {8'h00, mb(pa)};
    @(negedge clk);
    req = 1; seg_sel = s; offset = o; word = wd; wr = w; wdata = dat;
    @(posedge clk); #1 req = 0;
    for (int k = 0; k < ncyc; k++) begin
      logic [19:0] ea;
      logic        eb;
      int          wt;
      ea = (k == 0) ? pa : 20'(pa + 20'd1);
      eb = (k == 1) ? 1'b1 : ~(wd | pa[0]);
      wt = (maxw > 0) ? int'($urandom_range(maxw, 0)) : 0;
      if (poke && k == 0 && wt < 1) wt = 1;
      for (int j = 0; j <= wt; j++) begin
        @(negedge clk);
        ready = 0;
        if (poke && k == 0 && j == 1) req = 0;
        chk(bus_cyc === 1'b1, "R10 bus_cyc", 32'(bus_cyc), 1);
        chk(addr === ea, (j > 0) ? "R9 addr" : atag, 32'(addr), 32'(ea));
        chk(upper_en_n === eb, (j > 0) ? "R9 upper_en_n" : tag, 32'(upper_en_n), 32'(eb));
        chk(seg_stat === s, "R4 seg_stat", 32'(seg_stat), 32'(s));
        chk(bus_wr === w, tag, 32'(bus_wr), 32'(w));
        if (w) begin
          if (!wd && !pa[0])   chk(bus_wdata[7:0] === dat[7:0], "R5 lane", 32'(bus_wdata), 32'(dat[7:0]));
          else if (!wd)        chk(bus_wdata[15:8] === dat[7:0], "R6 lane", 32'(bus_wdata), 32'(dat[7:0]));
          else if (!pa[0])     chk(bus_wdata === dat, "R7 lane", 32'(bus_wdata), 32'(dat));
          else if (k == 0)     chk(bus_wdata[15:8] === dat[7:0], "R8 lane", 32'(bus_wdata), 32'(dat[7:0]));
          else                 chk(bus_wdata[7:0] === dat[15:8], "R8 lane", 32'(bus_wdata), 32'(dat[15:8]));
        end
        if (poke && k == 0 && j == 0) begin req = 1; offset = o ^ 16'h0101; word = ~wd; end
        if (j == wt) ready = 1;
      end
    end
    @(negedge clk);
    ready = 0;
    chk(done === 1'b1, "R10 done", 32'(done), 1);
    chk(bus_cyc === 1'b0, "R10 idle", 32'(bus_cyc), 0);
    if (!w) chk(rdata === exprd, tag, 32'(rdata), 32'(exprd));
    @(negedge clk);
    chk(done === 1'b0, "R10 pulse", 32'(done), 0);
    chk(bus_cyc === 1'b0, poke ? "R11 no extra cycle" : "R10 idle", 32'(bus_cyc), 0);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    segm[0] = 16'h0000; segm[1] = 16'h0000; segm[2] = 16'hFFFF; segm[3] = 16'h0000;
    repeat (5) @(negedge clk);
    chk(bus_cyc === 1'b0, "R2 bus_cyc", 32'(bus_cyc), 0);
    chk(done === 1'b0, "R2 done", 32'(done), 0);
    chk(upper_en_n === 1'b1, "R2 upper_en_n", 32'(upper_en_n), 1);
    rst_n = 1;
    xfer(2'b10, 16'h0000, 1, 0, 0, 0, 0, "R2 code fetch");
    xfer(2'b11, 16'h1234, 0, 0, 0, 0, 0, "R2 data base");
    xfer(2'b01, 16'h0042, 1, 0, 0, 0, 0, "R2 stack base");
    xfer(2'b00, 16'h8001, 0, 0, 0, 0, 0, "R2 extra base");
    seg_load(2'b11, 16'h2000);
    xfer(2'b11, 16'h0003, 0, 0, 0, 0, 0, "R3 loaded");
    xfer(2'b00, 16'h0005, 0, 0, 0, 0, 0, "R3 untouched");
    xfer(2'b10, 16'h0004, 0, 0, 0, 0, 0, "R3 untouched");
    seg_load(2'b00, 16'hFFFF);
    xfer(2'b00, 16'h0010, 1, 0, 0, 0, 0, "R1 wrap");
    xfer(2'b00, 16'h000F, 1, 0, 0, 0, 0, "R8 wrap");
    xfer(2'b00, 16'h000F, 1, 1, 16'hBEEF, 2, 0, "R8 wrap");
    xfer(2'b11, 16'h0100, 0, 1, 16'h00A5, 1, 0, "R5");
    xfer(2'b11, 16'h0101, 0, 1, 16'h003C, 1, 0, "R6");
    xfer(2'b11, 16'h0200, 1, 1, 16'h1357, 2, 0, "R7");
    xfer(2'b11, 16'h0201, 1, 1, 16'hC0DE, 2, 0, "R8");
    xfer(2'b11, 16'h0301, 1, 0, 0, 3, 1, "R11 poke");
    xfer(2'b01, 16'h0400, 0, 0, 0, 3, 1, "R11 poke");
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(7, 0) == 0) seg_load(2'($urandom), 16'($urandom));
      xfer(2'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 16'($urandom),
           2, ($urandom_range(9, 0) == 0), "R1");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule